// File: doc/BRIEF.md
# Delayed Load Alignment Unit

This block sits between the read port of a 32-bit little-endian data memory and the register file of a simple in-order core. For each load instruction it picks the addressed byte or halfword out of the raw memory word and extends it, or merges a partial word into the destination's old contents for the two unaligned-merge loads. It also flags misaligned halfword and word accesses.

The load result is not written to the register file when the load commits. It is parked in a pending pair, made of a destination index and a value. The pair is handed to the register file at the next advance of the pipeline, so the load has one instruction of delay. An advance is a successful commit or the entry to an exception. At each advance the old pair goes out on the writeback strobe, and the new pair, or an empty one, takes its place.

A merge load reads its old destination contents from the pending value when the pending pair targets the same register. This makes back-to-back merges into one register build up correctly.

Top module: `dlu_top`

## Requirements
- R1: Kind code 0 (signed byte) returns the byte in lane `addr_off_i` (lane n = word bits 8n+7:8n) with bit 7 copied into all upper bits.
- R2: Kind code 1 (unsigned byte) returns the same lane with all upper bits zero.
- R3: Kind codes 2 (signed half) and 3 (unsigned half) raise `addr_err_o` when offset bit 0 is 1. Otherwise they return lanes 1:0 (offset 0) or 3:2 (offset 2), sign-extended from bit 15 for code 2 and zero-extended for code 3.
- R4: Kind code 4 (word) raises `addr_err_o` for any nonzero offset. Otherwise it returns the whole word.
- R5: A committed load without error does not produce a writeback in its own cycle. The cycle after, `pend_idx_o`/`pend_val_o` hold its destination and result.
- R6: An advance is `stall_i`=0 with `commit_i` or `except_i` high. In an advance cycle, `wb_en_o` is 1 and `wb_idx_o`/`wb_val_o` present the pair that was pending before the edge. Outside an advance cycle, `wb_en_o` is 0.
- R7: A writeback whose index is 0 always carries value 0.
- R8: For kind codes 5 and 6, the old destination value is `pend_val_o` when `pend_idx_o` equals `dest_idx_i`, and `dest_cur_i` otherwise.
- R9: Kind code 5 (merge-left) at offset k returns the word shifted left by 8k bits, with the old value's low 8k bits kept.
- R10: Kind code 6 (merge-right) at offset k returns the word shifted right by 8(3-k) bits, with the old value's bits above 8(k+1) kept.
- R11: An advance caused by `except_i`, or by a commit that raises `addr_err_o`, still writes back the pending pair and leaves an empty pair (index 0, value 0).
- R12: With `stall_i` high, or with neither `commit_i` nor `except_i`, the pending pair is unchanged and `wb_en_o` is 0. A stall also overrides an exception.
- R13: A commit with kind code 7 (not a load) leaves an empty pair.
- R14: After reset the pending pair is empty and `wb_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| commit_i | input | 1 | Current instruction completes |
| except_i | input | 1 | Exception entry this cycle |
| stall_i | input | 1 | Pipeline held, no advance |
| kind_i | input | 3 | Load kind code (0..6, 7 = not a load) |
| addr_off_i | input | 2 | Low bits of the effective address |
| mem_word_i | input | 32 | Raw aligned memory word |
| dest_idx_i | input | 5 | Destination register index |
| dest_cur_i | input | 32 | Register file contents of the destination |
| load_val_o | output | 32 | Aligned or merged load result |
| addr_err_o | output | 1 | Misaligned access |
| wb_en_o | output | 1 | Pending pair written this cycle |
| wb_idx_o | output | 5 | Writeback register index |
| wb_val_o | output | 32 | Writeback value |
| pend_idx_o | output | 5 | Pending destination index |
| pend_val_o | output | 32 | Pending value |

## Verification
The extending kinds run against a word whose four lanes hold 01, FF, 7F and 80, at every offset. This separates lane order, sign fill and zero fill. The merge kinds run at each offset with old and new values that share no byte, so every kept or replaced lane is visible, and chained merges into one register show whether forwarding comes from the pending value or from the register file. Sequences of loads, stalls, idle cycles, exceptions, misaligned commits and loads to register 0 check the pending pair against a behavioural model on every cycle.

// File: rtl/dlu_pkg.sv
package dlu_pkg;
  localparam int DLU_DATA_W = 32;
  localparam int DLU_IDX_W  = 5;

  typedef enum logic [2:0] {
    LK_SBYTE = 3'd0,
    LK_UBYTE = 3'd1,
    LK_SHALF = 3'd2,
    LK_UHALF = 3'd3,
    LK_WORD  = 3'd4,
    LK_LEFT  = 3'd5,
    LK_RIGHT = 3'd6,
    LK_NONE  = 3'd7
  } load_kind_e;
endpackage

// File: rtl/dlu_align.sv
module dlu_align
  import dlu_pkg::*;
#(
  parameter int DATA_W = DLU_DATA_W,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  load_kind_e          kind,
  input  logic [OFF_W-1:0]    off,
  input  logic [DATA_W-1:0]   word,
  input  logic [DATA_W-1:0]   old_val,
  output logic [DATA_W-1:0]   value,
  output logic                misaligned
);

  // keep the low nbits of raw, fill the rest with the sign or zero
  function automatic logic [DATA_W-1:0] f_extend(input logic [DATA_W-1:0] raw,
                                                 input int nbits,
                                                 input logic sgn);
    logic [DATA_W-1:0] r;
    logic fill;
    fill = sgn & raw[nbits-1];
    for (int i = 0; i < DATA_W; i++) r[i] = (i < nbits) ? raw[i] : fill;
    return r;
  endfunction

  // word moves up by whole lanes, old keeps the lanes below
  function automatic logic [DATA_W-1:0] f_merge_left(input logic [DATA_W-1:0] w,
                                                     input logic [DATA_W-1:0] o,
                                                     input int k);
    int sh;
    logic [DATA_W-1:0] keep;
    sh   = 8 * k;
    keep = ~({DATA_W{1'b1}} << sh);
    return (w << sh) | (o & keep);
  endfunction

  // word moves down so its top lanes land low, old keeps the lanes above
  function automatic logic [DATA_W-1:0] f_merge_right(input logic [DATA_W-1:0] w,
                                                      input logic [DATA_W-1:0] o,
                                                      input int k);
    int sh;
    logic [DATA_W-1:0] keep;
    sh   = 8 * (LANES - 1 - k);
    keep = ~({DATA_W{1'b1}} >> sh);
    return (w >> sh) | (o & keep);
  endfunction

  function automatic logic f_misaligned(input load_kind_e k, input logic [OFF_W-1:0] o);
    case (k)
      LK_SHALF, LK_UHALF: return o[0];
      LK_WORD:            return |o;
      default:            return 1'b0;
    endcase
  endfunction

  logic [7:0] lanes [LANES];
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word[8*g +: 8];
  end

  logic [OFF_W-1:0]  half_base;
  logic [DATA_W-1:0] byte_raw;
  logic [DATA_W-1:0] half_raw;

  always_comb begin
    half_base = {off[OFF_W-1:1], 1'b0};
    byte_raw  = {{(DATA_W-8){1'b0}}, lanes[off]};
    half_raw  = {{(DATA_W-16){1'b0}}, lanes[half_base | OFF_W'(1)], lanes[half_base]};
  end

  always_comb begin
    case (kind)
      LK_SBYTE: value = f_extend(byte_raw, 8, 1'b1);
      LK_UBYTE: value = f_extend(byte_raw, 8, 1'b0);
      LK_SHALF: value = f_extend(half_raw, 16, 1'b1);
      LK_UHALF: value = f_extend(half_raw, 16, 1'b0);
      LK_WORD:  value = word;
      LK_LEFT:  value = f_merge_left(word, old_val, int'(off));
      LK_RIGHT: value = f_merge_right(word, old_val, int'(off));
      default:  value = '0;
    endcase
    misaligned = f_misaligned(kind, off);
  end

endmodule

// File: rtl/dlu_oldsel.sv
module dlu_oldsel
  import dlu_pkg::*;
#(
  parameter int DATA_W = DLU_DATA_W,
  parameter int IDX_W  = DLU_IDX_W
) (
  input  logic [IDX_W-1:0]  pend_idx,
  input  logic [DATA_W-1:0] pend_val,
  input  logic [IDX_W-1:0]  dest_idx,
  input  logic [DATA_W-1:0] dest_cur,
  output logic              fwd_hit,
  output logic [DATA_W-1:0] old_val
);
  // a load still in flight to the same register is newer than the file
  always_comb begin
    fwd_hit = (pend_idx == dest_idx);
    old_val = fwd_hit ? pend_val : dest_cur;
  end
endmodule

// File: rtl/dlu_pending.sv
module dlu_pending
  import dlu_pkg::*;
#(
  parameter int DATA_W = DLU_DATA_W,
  parameter int IDX_W  = DLU_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              install,
  input  logic [IDX_W-1:0]  new_idx,
  input  logic [DATA_W-1:0] new_val,
  output logic [IDX_W-1:0]  pend_idx,
  output logic [DATA_W-1:0] pend_val,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_val
);

  logic idx_is_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_idx <= '0;
      pend_val <= '0;
    end else if (advance) begin
      pend_idx <= install ? new_idx : '0;
      pend_val <= install ? new_val : '0;
    end
  end

  always_comb begin
    idx_is_zero = (pend_idx == '0);
    wb_en       = advance;
    wb_idx      = pend_idx;
    wb_val      = idx_is_zero ? '0 : pend_val;
  end

  // R12: no advance leaves the pair untouched
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> ($stable(pend_idx) && $stable(pend_val)));

  // R11 / R13: an advance without a new load leaves an empty pair
  assert_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !install) |=> (pend_idx == '0 && pend_val == '0));

endmodule

// File: rtl/dlu_top.sv
module dlu_top
  import dlu_pkg::*;
#(
  parameter int DATA_W = DLU_DATA_W,
  parameter int IDX_W  = DLU_IDX_W,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic              except_i,
  input  logic              stall_i,
  input  logic [2:0]        kind_i,
  input  logic [OFF_W-1:0]  addr_off_i,
  input  logic [DATA_W-1:0] mem_word_i,
  input  logic [IDX_W-1:0]  dest_idx_i,
  input  logic [DATA_W-1:0] dest_cur_i,
  output logic [DATA_W-1:0] load_val_o,
  output logic              addr_err_o,
  output logic              wb_en_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic [DATA_W-1:0] wb_val_o,
  output logic [IDX_W-1:0]  pend_idx_o,
  output logic [DATA_W-1:0] pend_val_o
);

  load_kind_e        kind;
  logic              is_load;
  logic              is_merge;
  logic              evt_advance;
  logic              evt_install;
  logic              fwd_hit;
  logic [DATA_W-1:0] old_val;

  always_comb begin
    kind        = load_kind_e'(kind_i);
    is_load     = (kind != LK_NONE);
    is_merge    = (kind == LK_LEFT) || (kind == LK_RIGHT);
    evt_advance = !stall_i && (commit_i || except_i);
    evt_install = evt_advance && commit_i && !except_i && is_load && !addr_err_o;
  end

  dlu_oldsel #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_oldsel (
    .pend_idx (pend_idx_o),
    .pend_val (pend_val_o),
    .dest_idx (dest_idx_i),
    .dest_cur (dest_cur_i),
    .fwd_hit  (fwd_hit),
    .old_val  (old_val)
  );

  dlu_align #(.DATA_W(DATA_W)) u_align (
    .kind       (kind),
    .off        (addr_off_i),
    .word       (mem_word_i),
    .old_val    (old_val),
    .value      (load_val_o),
    .misaligned (addr_err_o)
  );

  dlu_pending #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pending (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (evt_advance),
    .install  (evt_install),
    .new_idx  (dest_idx_i),
    .new_val  (load_val_o),
    .pend_idx (pend_idx_o),
    .pend_val (pend_val_o),
    .wb_en    (wb_en_o),
    .wb_idx   (wb_idx_o),
    .wb_val   (wb_val_o)
  );

  assert_sbyte_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LK_SBYTE) |-> (load_val_o[DATA_W-1:8] == {(DATA_W-8){load_val_o[7]}}));

  assert_ubyte_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LK_UBYTE) |-> (load_val_o[DATA_W-1:8] == '0));

  assert_half_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == LK_SHALF || kind == LK_UHALF) && addr_off_i[0]) |-> addr_err_o);

  assert_word_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LK_WORD && addr_off_i != '0) |-> addr_err_o);

  assert_install_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_install |=> (pend_idx_o == $past(dest_idx_i) && pend_val_o == $past(load_val_o)));

  // R8: a right merge at offset 0 keeps upper lanes of the forwarded value
  assert_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LK_RIGHT && addr_off_i == '0 && pend_idx_o == dest_idx_i)
      |-> (load_val_o[DATA_W-1:8] == pend_val_o[DATA_W-1:8]));

  assert_left_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LK_LEFT && addr_off_i == '0) |-> (load_val_o == mem_word_i));

  assert_right_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LK_RIGHT && addr_off_i == OFF_W'(LANES-1)) |-> (load_val_o == mem_word_i));

  // R6: a stalled cycle never writes back
  assert_no_wb_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> !wb_en_o);

  // is_merge and fwd_hit are brought out for waveform inspection
  logic unused_dbg;
  assign unused_dbg = is_merge ^ fwd_hit;

endmodule

// File: tb/dlu_top_test.sv
module dlu_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        commit_i = 1'b0, except_i = 1'b0, stall_i = 1'b0;
  logic [2:0]  kind_i = 3'd7;
  logic [1:0]  addr_off_i = 2'd0;
  logic [31:0] mem_word_i = '0, dest_cur_i = '0;
  logic [4:0]  dest_idx_i = '0;
  logic [31:0] load_val_o, wb_val_o, pend_val_o;
  logic        addr_err_o, wb_en_o;
  logic [4:0]  wb_idx_o, pend_idx_o;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [4:0]  m_idx = '0;
  logic [31:0] m_val = '0;

  always #4 clk = ~clk;  // 125 MHz

  dlu_top uut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic ref_err(input int k, input int o);
    if (k == 2 || k == 3) return (o % 2) != 0;
    if (k == 4) return o != 0;
    return 1'b0;
  endfunction

  function automatic logic [31:0] ref_val(input int k, input int o, input logic [31:0] w, input logic [31:0] old);
    logic [31:0] b, h;
    b = (w >> (8 * o)) & 32'hFF;
    h = (w >> ((o >= 2) ? 16 : 0)) & 32'hFFFF;
    case (k)
      0: return (b >= 128) ? (b | 32'hFFFFFF00) : b;
      1: return b;
      2: return (h >= 32768) ? (h | 32'hFFFF0000) : h;
      3: return h;
      4: return w;
      5: case (o)
           0: return w;
           1: return (w << 8)  | (old & 32'h000000FF);
           2: return (w << 16) | (old & 32'h0000FFFF);
           default: return (w << 24) | (old & 32'h00FFFFFF);
         endcase
      6: case (o)
           0: return (old & 32'hFFFFFF00) | (w >> 24);
           1: return (old & 32'hFFFF0000) | (w >> 16);
           2: return (old & 32'hFF000000) | (w >> 8);
           default: return w;
         endcase
      default: return 32'h0;
    endcase
  endfunction

  task automatic cyc(input int k, input int o, input logic [31:0] w, input int d,
                     input logic [31:0] cur, input logic cm, input logic ex,
                     input logic st, input string tag);
    logic [31:0] old, ev;
    logic ee, adv;
    @(negedge clk);
    kind_i = 3'(k); addr_off_i = 2'(o); mem_word_i = w; dest_idx_i = 5'(d);
    dest_cur_i = cur; commit_i = cm; except_i = ex; stall_i = st;
    #1;
    old = (m_idx == 5'(d)) ? m_val : cur;
    ee  = ref_err(k, o);
    ev  = ref_val(k, o, w, old);
    adv = !st && (cm || ex);
    if (k != 7) chk(32'(addr_err_o), 32'(ee), tag, "addr_err");
    if (k != 7 && !ee) chk(load_val_o, ev, tag, "load_val");
    chk(32'(pend_idx_o), 32'(m_idx), "R5", "pend_idx");
    chk(pend_val_o, m_val, "R5", "pend_val");
    chk(32'(wb_en_o), 32'(adv), st ? "R12" : "R6", "wb_en");
    if (adv) begin
      chk(32'(wb_idx_o), 32'(m_idx), "R6", "wb_idx");
      chk(wb_val_o, (m_idx == 0) ? 32'h0 : m_val, (m_idx == 0) ? "R7" : "R6", "wb_val");
      if (cm && !ex && k != 7 && !ee) begin
        m_idx = 5'(d); m_val = ev;
      end else begin
        m_idx = '0; m_val = '0;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(32'(pend_idx_o), 0, "R14", "pend_idx in reset");
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(32'(pend_idx_o), 0, "R14", "pend_idx");
    chk(pend_val_o, 0, "R14", "pend_val");
    chk(32'(wb_en_o), 0, "R14", "wb_en");

    for (int o = 0; o < 4; o++) cyc(0, o, 32'h807FFF01, 3, 0, 1, 0, 0, "R1");
    for (int o = 0; o < 4; o++) cyc(1, o, 32'h807FFF01, 4, 0, 1, 0, 0, "R2");
    for (int o = 0; o < 4; o++) cyc(2, o, 32'h80017FFE, 5, 0, 1, 0, 0, "R3");
    for (int o = 0; o < 4; o++) cyc(3, o, 32'h80017FFE, 6, 0, 1, 0, 0, "R3");
    for (int o = 0; o < 4; o++) cyc(4, o, 32'hCAFEF00D, 7, 0, 1, 0, 0, "R4");
    cyc(7, 0, 0, 0, 0, 1, 0, 0, "R11");

    cyc(4, 0, 32'h12345678, 9, 0, 1, 0, 0, "R5");
    cyc(4, 0, 32'h0000DEAD, 10, 0, 1, 0, 1, "R12");
    cyc(7, 0, 0, 0, 0, 0, 0, 0, "R12");
    cyc(4, 0, 32'h00001111, 11, 0, 1, 1, 1, "R12");
    cyc(4, 0, 32'h00001111, 11, 0, 1, 1, 0, "R11");
    cyc(4, 0, 32'h00002222, 12, 0, 1, 0, 0, "R6");
    cyc(7, 0, 0, 0, 0, 1, 0, 0, "R13");
    cyc(7, 0, 0, 0, 0, 1, 0, 0, "R13");

    cyc(4, 0, 32'hFFFFFFFF, 0, 0, 1, 0, 0, "R7");
    cyc(7, 0, 0, 0, 0, 1, 0, 0, "R7");

    for (int o = 0; o < 4; o++) cyc(5, o, 32'hA1B2C3D4, 12 + o, 32'h55667788, 1, 0, 0, "R9");
    for (int o = 0; o < 4; o++) cyc(6, o, 32'hA1B2C3D4, 24 + o, 32'h55667788, 1, 0, 0, "R10");

    cyc(4, 0, 32'h0BADF00D, 20, 0, 1, 0, 0, "R8");
    cyc(5, 1, 32'hA1B2C3D4, 20, 32'h99999999, 1, 0, 0, "R8");
    cyc(6, 0, 32'h11223344, 20, 32'h99999999, 1, 0, 0, "R8");
    cyc(6, 2, 32'h11223344, 21, 32'h99999999, 1, 0, 0, "R8");
    cyc(5, 3, 32'h11223344, 21, 32'h99999999, 1, 0, 0, "R8");
    cyc(7, 0, 0, 0, 0, 1, 0, 0, "R6");
    cyc(7, 0, 0, 0, 0, 0, 0, 0, "R12");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule